// File: doc/BRIEF.md
# Interrupt Priority and In-Service Tracker

This block keeps the interrupt state of one processor core across 256 vectors. It holds three bitmaps: one for requests waiting to be served, one for vectors being serviced, and one that records whether each vector was last requested as level-triggered. It also holds a task priority value. From that value and the highest vector in service it derives a processor priority.

Fixed-mode requests arrive as a vector and a trigger flag. The block tells the core when a waiting vector outranks the current processor priority. An acknowledge moves that vector from waiting to in-service. An end-of-interrupt strobe retires the highest in-service vector and reports it, with its trigger flag, on a notify port one cycle later. Requests are dropped while either the hardware enable or the software enable input is low.

Top module: `vec_prio_tracker`

## Requirements
- R1: After reset all three bitmaps are empty. `taskPrio` and `procPrio` read 0x00, and `intPending` and `eoiValid` are 0.
- R2: A request (`reqValid`) made while both enables are high, for a vector whose waiting bit is clear, raises `reqAccepted` in the same cycle. From the next cycle on, that vector counts as waiting. Its level bit takes the value of `reqLevel` (1 = level, 0 = edge).
- R3: A request for a vector that is already waiting raises `reqCoalesced` and not `reqAccepted`, and leaves the set of waiting vectors unchanged.
- R4: While `hwEnable` or `swEnable` is low, a request sets neither `reqAccepted` nor `reqCoalesced` and is lost. `intPending` is held at 0 during that time.
- R5: `intVector` is the highest waiting vector. `intPending` is 1 exactly when a vector is waiting and (`intVector` & 0xF0) > `procPrio`, compared as 8-bit values.
- R6: `procPrio` equals `taskPrio` when `taskPrio`[7:4] >= bits [7:4] of the highest in-service vector, where an empty in-service set counts as 0. Otherwise `procPrio` equals that vector & 0xF0.
- R7: A `tprWrite` stores `tprData` into `taskPrio`. Both `taskPrio` and `procPrio` reflect the new value from the next cycle.
- R8: `ackStrobe` while `intPending` is 1 moves `intVector` from waiting to in-service. While `intPending` is 0, `ackStrobe` has no effect.
- R9: `eoiStrobe` with a non-empty in-service set clears the highest in-service vector. In the next cycle it raises `eoiValid` for one cycle, with `eoiVector` set to that vector and `eoiLevel` set to its level bit. With an empty in-service set, `eoiStrobe` changes nothing and `eoiValid` stays 0.
- R10: The highest-vector search covers all eight 32-vector groups. Vector v belongs to group v[7:5] at position v[4:0]. A higher group always beats a lower one, for example 0x40 beats 0x2F.
- R11: An accepted request updates the level bit even when the vector is currently in service. The trigger flag reported at end-of-interrupt is therefore the one from the latest request for that vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hwEnable | input | 1 | Hardware enable |
| swEnable | input | 1 | Software enable |
| reqValid | input | 1 | Fixed-mode request strobe |
| reqVector | input | 8 | Requested vector |
| reqLevel | input | 1 | 1 = level-triggered request, 0 = edge |
| reqAccepted | output | 1 | Request taken this cycle |
| reqCoalesced | output | 1 | Request merged with an already waiting one |
| tprWrite | input | 1 | Task priority write strobe |
| tprData | input | 8 | Task priority write value |
| taskPrio | output | 8 | Current task priority |
| procPrio | output | 8 | Derived processor priority |
| intPending | output | 1 | A deliverable vector exists |
| intVector | output | 8 | Highest waiting vector |
| ackStrobe | input | 1 | Core acknowledge |
| eoiStrobe | input | 1 | End-of-interrupt strobe |
| eoiValid | output | 1 | Retirement notify pulse |
| eoiVector | output | 8 | Retired vector |
| eoiLevel | output | 1 | Level bit of the retired vector |

## Verification
The hardest state to reach is two nested in-service vectors in different priority classes, with task priority values placed on both sides of the class boundary. Only that state shows whether the priority rule and end-of-interrupt ordering pick the right vector. The stimulus builds it by accepting and acknowledging a low vector, then a higher one, and then writing task priorities just above, equal to and one below a class before retiring vectors one at a time. A second directed case re-requests a vector while it is in service with the opposite trigger flag, so the notify port shows which request last set the level bit.

// File: rtl/vec_prio_pkg.sv
package vec_prio_pkg;
  localparam int VEC_W   = 8;
  localparam int NUM_VEC = 1 << VEC_W;
  localparam int CLASS_W = 4;

  typedef logic [VEC_W-1:0] vec_t;

  typedef struct packed {
    logic irrSet;
    vec_t reqVec;
    logic tmrWr;
    logic tmrVal;
    logic ackDo;
    vec_t ackVec;
    logic eoiDo;
    vec_t eoiVec;
    logic tprWr;
    vec_t tprVal;
  } strobe_t;
endpackage

// File: rtl/vec_top_finder.sv
module vec_top_finder #(
  parameter int NUM_BITS = 256,
  parameter int WORD_W   = 32
) (
  input  logic [NUM_BITS-1:0]         bits,
  output logic                        found,
  output logic [$clog2(NUM_BITS)-1:0] idx
);
  localparam int NUM_WORDS = NUM_BITS / WORD_W;
  localparam int BIT_W     = $clog2(WORD_W);
  localparam int SEL_W     = $clog2(NUM_WORDS);

  logic [NUM_WORDS-1:0] wordNz;
  logic [BIT_W-1:0]     wordPos [NUM_WORDS];
  logic [SEL_W-1:0]     wordSel;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_comb begin
      wordPos[w] = '0;
      for (int b = 0; b < WORD_W; b++) begin
        if (bits[w*WORD_W + b]) wordPos[w] = BIT_W'(b);
      end
    end
    assign wordNz[w] = |bits[w*WORD_W +: WORD_W];
  end

  always_comb begin
    wordSel = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (wordNz[w]) wordSel = SEL_W'(w);
    end
  end

  assign found = |wordNz;
  assign idx   = {wordSel, wordPos[wordSel]};
endmodule

// File: rtl/vec_prio_ctrl.sv
module vec_prio_ctrl
  import vec_prio_pkg::*;
(
  input  logic    hwEnable,
  input  logic    swEnable,
  input  logic    reqValid,
  input  vec_t    reqVector,
  input  logic    reqLevel,
  input  logic    tprWrite,
  input  vec_t    tprData,
  input  logic    ackStrobe,
  input  logic    eoiStrobe,
  input  logic    irrHit,
  input  logic    irrFound,
  input  vec_t    irrTop,
  input  logic    isrFound,
  input  vec_t    isrTop,
  input  vec_t    taskPrio,
  output vec_t    procPrio,
  output logic    intPending,
  output logic    reqAccepted,
  output logic    reqCoalesced,
  output strobe_t strobes
);
  localparam int LOW_W = VEC_W - CLASS_W;

  logic               enabled;
  logic [CLASS_W-1:0] isrClass;
  logic [CLASS_W-1:0] tprClass;
  vec_t               irrClassVal;

  assign enabled     = hwEnable & swEnable;
  assign isrClass    = isrFound ? isrTop[VEC_W-1 -: CLASS_W] : '0;
  assign tprClass    = taskPrio[VEC_W-1 -: CLASS_W];
  assign procPrio    = (tprClass >= isrClass) ? taskPrio : {isrClass, {LOW_W{1'b0}}};
  assign irrClassVal = {irrTop[VEC_W-1 -: CLASS_W], {LOW_W{1'b0}}};
  assign intPending  = enabled & irrFound & (irrClassVal > procPrio);

  assign reqAccepted  = reqValid & enabled & ~irrHit;
  assign reqCoalesced = reqValid & enabled & irrHit;

  always_comb begin
    strobes        = '0;
    strobes.irrSet = reqAccepted;
    strobes.reqVec = reqVector;
    strobes.tmrWr  = reqValid & enabled;
    strobes.tmrVal = reqLevel;
    strobes.ackDo  = ackStrobe & intPending;
    strobes.ackVec = irrTop;
    strobes.eoiDo  = eoiStrobe & isrFound;
    strobes.eoiVec = isrTop;
    strobes.tprWr  = tprWrite;
    strobes.tprVal = tprData;
  end
endmodule

// File: rtl/vec_prio_dpath.sv
module vec_prio_dpath
  import vec_prio_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobes,
  input  vec_t               reqVector,
  output logic [NUM_VEC-1:0] irrBits,
  output logic [NUM_VEC-1:0] isrBits,
  output logic               irrHit,
  output vec_t               taskPrio,
  output logic               eoiValid,
  output vec_t               eoiVector,
  output logic               eoiLevel
);
  logic [NUM_VEC-1:0] tmrBits;

  assign irrHit = irrBits[reqVector];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irrBits   <= '0;
      isrBits   <= '0;
      tmrBits   <= '0;
      taskPrio  <= '0;
      eoiValid  <= 1'b0;
      eoiVector <= '0;
      eoiLevel  <= 1'b0;
    end else begin
      if (strobes.ackDo) begin
        irrBits[strobes.ackVec] <= 1'b0;
        isrBits[strobes.ackVec] <= 1'b1;
      end
      if (strobes.irrSet) irrBits[strobes.reqVec] <= 1'b1;
      if (strobes.tmrWr)  tmrBits[strobes.reqVec] <= strobes.tmrVal;
      if (strobes.eoiDo)  isrBits[strobes.eoiVec] <= 1'b0;
      if (strobes.tprWr)  taskPrio <= strobes.tprVal;
      eoiValid <= strobes.eoiDo;
      if (strobes.eoiDo) begin
        eoiVector <= strobes.eoiVec;
        eoiLevel  <= tmrBits[strobes.eoiVec];
      end
    end
  end
endmodule

// File: rtl/vec_prio_tracker.sv
module vec_prio_tracker
  import vec_prio_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hwEnable,
  input  logic       swEnable,
  input  logic       reqValid,
  input  logic [7:0] reqVector,
  input  logic       reqLevel,
  output logic       reqAccepted,
  output logic       reqCoalesced,
  input  logic       tprWrite,
  input  logic [7:0] tprData,
  output logic [7:0] taskPrio,
  output logic [7:0] procPrio,
  output logic       intPending,
  output logic [7:0] intVector,
  input  logic       ackStrobe,
  input  logic       eoiStrobe,
  output logic       eoiValid,
  output logic [7:0] eoiVector,
  output logic       eoiLevel
);
  strobe_t            strobes;
  logic [NUM_VEC-1:0] irrBits;
  logic [NUM_VEC-1:0] isrBits;
  logic               irrHit;
  logic               irrFound;
  logic               isrFound;
  vec_t               isrTop;

  vec_top_finder #(.NUM_BITS(NUM_VEC), .WORD_W(WORD_W)) u_irrFind (
    .bits(irrBits), .found(irrFound), .idx(intVector)
  );

  vec_top_finder #(.NUM_BITS(NUM_VEC), .WORD_W(WORD_W)) u_isrFind (
    .bits(isrBits), .found(isrFound), .idx(isrTop)
  );

  vec_prio_ctrl u_ctrl (
    .hwEnable(hwEnable), .swEnable(swEnable), .reqValid(reqValid),
    .reqVector(reqVector), .reqLevel(reqLevel), .tprWrite(tprWrite),
    .tprData(tprData), .ackStrobe(ackStrobe), .eoiStrobe(eoiStrobe),
    .irrHit(irrHit), .irrFound(irrFound), .irrTop(intVector),
    .isrFound(isrFound), .isrTop(isrTop), .taskPrio(taskPrio),
    .procPrio(procPrio), .intPending(intPending), .reqAccepted(reqAccepted),
    .reqCoalesced(reqCoalesced), .strobes(strobes)
  );

  vec_prio_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqVector(reqVector),
    .irrBits(irrBits), .isrBits(isrBits), .irrHit(irrHit),
    .taskPrio(taskPrio), .eoiValid(eoiValid), .eoiVector(eoiVector),
    .eoiLevel(eoiLevel)
  );
endmodule

// File: rtl/vec_prio_tracker_chk.sv
module vec_prio_tracker_chk
  import vec_prio_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               hwEnable,
  input logic               swEnable,
  input logic               reqValid,
  input logic [7:0]         reqVector,
  input logic               tprWrite,
  input logic [7:0]         tprData,
  input logic [7:0]         taskPrio,
  input logic [7:0]         procPrio,
  input logic               intPending,
  input logic [7:0]         intVector,
  input logic               ackStrobe,
  input logic               eoiStrobe,
  input logic               eoiValid,
  input logic [NUM_VEC-1:0] irrBits,
  input logic [NUM_VEC-1:0] isrBits,
  input logic               isrFound
);
  // R6
  ppr_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    procPrio >= taskPrio);

  // R5
  pending_class_chk: assert property (@(posedge clk) disable iff (!rstN)
    intPending |-> (intVector[7:4] > procPrio[7:4]));

  // R7
  tpr_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    tprWrite |=> (taskPrio == $past(tprData)));

  // R8
  ack_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && intPending && !(reqValid && reqVector == intVector))
    |=> (isrBits[$past(intVector)] && !irrBits[$past(intVector)]));

  // R4
  disabled_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !(hwEnable && swEnable) && !ackStrobe) |=> (irrBits == $past(irrBits)));

  // R9
  eoi_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eoiStrobe && !isrFound) |=> !eoiValid);
endmodule

bind vec_prio_tracker vec_prio_tracker_chk u_chk (
  .clk(clk), .rstN(rstN), .hwEnable(hwEnable), .swEnable(swEnable),
  .reqValid(reqValid), .reqVector(reqVector), .tprWrite(tprWrite),
  .tprData(tprData), .taskPrio(taskPrio), .procPrio(procPrio),
  .intPending(intPending), .intVector(intVector), .ackStrobe(ackStrobe),
  .eoiStrobe(eoiStrobe), .eoiValid(eoiValid), .irrBits(irrBits),
  .isrBits(isrBits), .isrFound(isrFound)
);

// File: tb/sim_vec_prio_tracker.sv
module sim_vec_prio_tracker;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hwEnable = 1'b1, swEnable = 1'b1;
  logic       reqValid = 1'b0, reqLevel = 1'b0;
  logic [7:0] reqVector = '0;
  logic       tprWrite = 1'b0;
  logic [7:0] tprData = '0;
  logic       ackStrobe = 1'b0, eoiStrobe = 1'b0;
  logic       reqAccepted, reqCoalesced, intPending, eoiValid, eoiLevel;
  logic [7:0] taskPrio, procPrio, intVector, eoiVector;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  vec_prio_tracker u0 (.*);

  localparam logic [1:0] OP_REQ = 2'd0, OP_TPR = 2'd1, OP_ACK = 2'd2, OP_EOI = 2'd3;

  // {op, data, level, expPend, expVec, expPpr, expEoiValid, expEoiVec, expEoiLvl}
  localparam int NSTEP = 15;
  localparam logic [37:0] STEPS [NSTEP] = '{
    {OP_REQ, 8'h31, 1'b0, 1'b1, 8'h31, 8'h00, 1'b0, 8'h00, 1'b0},
    {OP_REQ, 8'h45, 1'b1, 1'b1, 8'h45, 8'h00, 1'b0, 8'h00, 1'b0},
    {OP_ACK, 8'h00, 1'b0, 1'b0, 8'h31, 8'h40, 1'b0, 8'h00, 1'b0},
    {OP_REQ, 8'h7A, 1'b0, 1'b1, 8'h7A, 8'h40, 1'b0, 8'h00, 1'b0},
    {OP_ACK, 8'h00, 1'b0, 1'b0, 8'h31, 8'h70, 1'b0, 8'h00, 1'b0},
    {OP_TPR, 8'h82, 1'b0, 1'b0, 8'h31, 8'h82, 1'b0, 8'h00, 1'b0},
    {OP_EOI, 8'h00, 1'b0, 1'b0, 8'h31, 8'h82, 1'b1, 8'h7A, 1'b0},
    {OP_TPR, 8'h20, 1'b0, 1'b0, 8'h31, 8'h40, 1'b0, 8'h00, 1'b0},
    {OP_EOI, 8'h00, 1'b0, 1'b1, 8'h31, 8'h20, 1'b1, 8'h45, 1'b1},
    {OP_REQ, 8'h2F, 1'b0, 1'b1, 8'h31, 8'h20, 1'b0, 8'h00, 1'b0},
    {OP_TPR, 8'h30, 1'b0, 1'b0, 8'h31, 8'h30, 1'b0, 8'h00, 1'b0},
    {OP_TPR, 8'h2F, 1'b0, 1'b1, 8'h31, 8'h2F, 1'b0, 8'h00, 1'b0},
    {OP_ACK, 8'h00, 1'b0, 1'b0, 8'h2F, 8'h30, 1'b0, 8'h00, 1'b0},
    {OP_EOI, 8'h00, 1'b0, 1'b0, 8'h2F, 8'h2F, 1'b1, 8'h31, 1'b0},
    {OP_REQ, 8'h40, 1'b1, 1'b1, 8'h40, 8'h2F, 1'b0, 8'h00, 1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Called just after a negedge; returns just after the following negedge.
  task automatic doOp(input logic [1:0] op, input logic [7:0] data, input logic lvl);
    case (op)
      OP_REQ: begin reqValid = 1'b1; reqVector = data; reqLevel = lvl; end
      OP_TPR: begin tprWrite = 1'b1; tprData = data; end
      OP_ACK: ackStrobe = 1'b1;
      default: eoiStrobe = 1'b1;
    endcase
    #1;
    @(posedge clk);
    #1;
    reqValid = 1'b0; tprWrite = 1'b0; ackStrobe = 1'b0; eoiStrobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic chkState(input string tag, input logic pend, input logic [7:0] vec,
                          input logic [7:0] ppr);
    chk({tag, " R5 intPending"}, int'(intPending), int'(pend));
    chk({tag, " R10 intVector"}, int'(intVector), int'(vec));
    chk({tag, " R6 procPrio"}, int'(procPrio), int'(ppr));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 intPending", int'(intPending), 0);
    chk("R1 procPrio", int'(procPrio), 0);
    chk("R1 taskPrio", int'(taskPrio), 0);
    chk("R1 eoiValid", int'(eoiValid), 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NSTEP; i++) begin
      logic [37:0] s;
      s = STEPS[i];
      if (s[37:36] == OP_REQ) begin
        reqValid = 1'b1; reqVector = s[35:28]; reqLevel = s[27];
        #1;
        chk("R2 reqAccepted", int'(reqAccepted), 1);
        reqValid = 1'b0;
      end
      doOp(s[37:36], s[35:28], s[27]);
      chkState("table", s[26], s[25:18], s[17:10]);
      chk("table R9 eoiValid", int'(eoiValid), int'(s[9]));
      if (s[9]) begin
        chk("table R9 eoiVector", int'(eoiVector), int'(s[8:1]));
        chk("table R9 eoiLevel", int'(eoiLevel), int'(s[0]));
      end
      if (s[37:36] == OP_TPR) chk("table R7 taskPrio", int'(taskPrio), int'(s[35:28]));
    end

    // R3: coalesced request for waiting vector 0x40
    reqValid = 1'b1; reqVector = 8'h40; reqLevel = 1'b1;
    #1;
    chk("R3 reqCoalesced", int'(reqCoalesced), 1);
    chk("R3 reqAccepted", int'(reqAccepted), 0);
    reqValid = 1'b0;
    doOp(OP_REQ, 8'h40, 1'b1);
    chkState("R3 after", 1'b1, 8'h40, 8'h2F);

    // R8: acknowledge while nothing deliverable is ignored
    doOp(OP_TPR, 8'hFF, 1'b0);
    chkState("R8 masked", 1'b0, 8'h40, 8'hFF);
    doOp(OP_ACK, 8'h00, 1'b0);
    doOp(OP_TPR, 8'h00, 1'b0);
    chkState("R8 ignored ack", 1'b1, 8'h40, 8'h00);

    // R9: end-of-interrupt with empty in-service set
    doOp(OP_EOI, 8'h00, 1'b0);
    chk("R9 empty eoiValid", int'(eoiValid), 0);
    chkState("R9 empty", 1'b1, 8'h40, 8'h00);

    // R4: hardware enable low
    hwEnable = 1'b0;
    reqValid = 1'b1; reqVector = 8'h90; reqLevel = 1'b0;
    #1;
    chk("R4 hw reqAccepted", int'(reqAccepted), 0);
    chk("R4 hw reqCoalesced", int'(reqCoalesced), 0);
    chk("R4 hw intPending", int'(intPending), 0);
    reqValid = 1'b0;
    doOp(OP_REQ, 8'h90, 1'b0);
    hwEnable = 1'b1;
    #1;
    chkState("R4 hw dropped", 1'b1, 8'h40, 8'h00);
    // R4: software enable low
    swEnable = 1'b0;
    reqValid = 1'b1; reqVector = 8'hA0;
    #1;
    chk("R4 sw reqAccepted", int'(reqAccepted), 0);
    reqValid = 1'b0;
    doOp(OP_REQ, 8'hA0, 1'b0);
    swEnable = 1'b1;
    #1;
    chkState("R4 sw dropped", 1'b1, 8'h40, 8'h00);
    @(negedge clk);

    // R11: re-request while in service with the other trigger flag
    doOp(OP_REQ, 8'h50, 1'b1);
    chkState("R11 req", 1'b1, 8'h50, 8'h00);
    doOp(OP_ACK, 8'h00, 1'b0);
    chkState("R11 ack", 1'b0, 8'h40, 8'h50);
    reqValid = 1'b1; reqVector = 8'h50; reqLevel = 1'b0;
    #1;
    chk("R11 reqAccepted", int'(reqAccepted), 1);
    reqValid = 1'b0;
    doOp(OP_REQ, 8'h50, 1'b0);
    chkState("R11 rereq", 1'b0, 8'h50, 8'h50);
    doOp(OP_EOI, 8'h00, 1'b0);
    chk("R11 eoiValid", int'(eoiValid), 1);
    chk("R11 eoiVector", int'(eoiVector), 8'h50);
    chk("R11 eoiLevel", int'(eoiLevel), 0);
    chkState("R11 after eoi", 1'b1, 8'h50, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule